// File: doc/BRIEF.md
# Registered SECDED Decoder for 8-bit Words

This block receives a 13-bit protected word, made of 8 data bits and 5 check bits, and returns the 8 data bits after one rising clock edge, together with three status flags. It forms a 5-bit syndrome from the word. Four syndrome bits give a Hamming position, and the fifth is an overall parity result that is set when an odd number of bits has flipped. A single flipped data bit is inverted back to its correct value. A single flipped check bit leaves the data alone and raises no flag. Two flipped bits are reported as fatal, and the data passes through unchanged.

The data output and the flags are held in one register stage. An active-high asynchronous clear empties that stage at once, without waiting for a clock edge. A system can use it to discard a word flagged as fatal. The data width is a parameter, with the check width derived from it. The numbering of bit positions shown here applies to the default width of 8.

Top module: `secded_dec13`

## Requirements
- R1: The word layout is as follows. Data bit i sits in code_in[i], for i from 0 to 7. Data bits 0 to 7 take Hamming positions 3, 5, 6, 7, 9, 10, 11 and 12, in that order. code_in[8+j] is the even-parity check over the positions whose bit j is set, for j from 0 to 3. code_in[12] is even parity over code_in[11:0]. The example word 0x14F0 is valid and carries data 0xF0.
- R2: The syndrome is formed as follows. Syndrome bit j, for j from 0 to 3, is code_in[8+j] XOR the parity of the data bits it covers. Syndrome bit 4 is the parity of all 13 bits. Word 0x14F1 gives syndrome 1_0011 and is decoded to data 0xF0.
- R3: A valid word gives data_out equal to code_in[7:0], and all three flags low.
- R4: A single flipped data bit is corrected. The flags are err_any=1, err_fixed=1 and err_fatal=0.
- R5: A single flipped check bit, including code_in[12], gives data_out = code_in[7:0] and all flags low.
- R6: Two flipped bits give data_out = code_in[7:0] without correction. The flags are err_any=1, err_fatal=1 and err_fixed=0. Example: 0x14F3 is decoded to 0xF3.
- R7: A syndrome with bit 4 set and a position above 12 is uncorrectable. It gives err_any=1, err_fatal=1, err_fixed=0, and data passed through unchanged. Example: 0x19F0 is decoded to 0xF0.
- R8: The result for the word applied before a rising clock edge appears on the outputs after that edge. The outputs do not change between edges.
- R9: While async_clr is high, data_out and all flags are 0. This holds immediately, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| async_clr | input | 1 | Active-high asynchronous clear of outputs and flags |
| code_in | input | 13 | Protected word: data in [7:0], check bits in [12:8] |
| data_out | output | 8 | Registered data, corrected where possible |
| err_any | output | 1 | Registered: an error was seen in the data or was uncorrectable |
| err_fixed | output | 1 | Registered: a single data-bit error was corrected |
| err_fatal | output | 1 | Registered: the error cannot be corrected |

## Verification
The bench builds the block with its default data width of 8. This yields a 13-bit word and a 5-bit syndrome. At this size every data value can be combined with every zero-, one- and two-bit flip pattern: 256 words, each with 92 patterns. Every syndrome class is therefore reached from every valid word: clean, corrected data bit, silent check bit and double error. Directed words cover the out-of-range position case, the one-edge latency, and a clear pulse taken between clock edges.

// File: rtl/secded_pkg.sv
package secded_pkg;

   // Number of Hamming check bits needed for dw data bits (overall parity excluded)
   function automatic int unsigned par_bits(int unsigned dw);
      int unsigned r;
      r = 1;
      while ((1 << r) < (dw + r + 1)) r++;
      return r;
   endfunction

   // Hamming position of data bit idx: the idx-th position that is not a power of two
   function automatic int unsigned data_pos(int unsigned idx);
      int unsigned cnt;
      int unsigned res;
      cnt = 0;
      res = 0;
      for (int unsigned p = 1; p < 128; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (cnt == idx && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

   // Data bits covered by check bit j
   function automatic logic [63:0] cover_mask(int unsigned bitj, int unsigned dw);
      logic [63:0] m;
      m = '0;
      for (int unsigned i = 0; i < dw; i++) begin
         m[i] = ((data_pos(i) >> bitj) & 1) != 0;
      end
      return m;
   endfunction

endpackage

// File: rtl/secded_syndrome.sv
module secded_syndrome
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PAR_W  = par_bits(DATA_W),
   localparam int unsigned CODE_W = DATA_W + PAR_W + 1
) (
   input  logic [CODE_W-1:0] code,
   output logic [PAR_W:0]    syn
);

   logic [DATA_W-1:0] data;
   assign data = code[DATA_W-1:0];

   for (genvar j = 0; j < PAR_W; j++) begin : g_chk
      localparam logic [63:0] MASK = cover_mask(j, DATA_W);
      assign syn[j] = code[DATA_W+j] ^ (^(data & MASK[DATA_W-1:0]));
   end

   assign syn[PAR_W] = ^code;

endmodule

// File: rtl/secded_locate.sv
module secded_locate
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PAR_W = par_bits(DATA_W)
) (
   input  logic [PAR_W:0]    syn,
   output logic [DATA_W-1:0] flip,
   output logic              data_hit,
   output logic              chk_hit,
   output logic              fatal
);

   logic [PAR_W-1:0] pos;
   logic             odd;

   assign pos = syn[PAR_W-1:0];
   assign odd = syn[PAR_W];

   for (genvar i = 0; i < DATA_W; i++) begin : g_hit
      localparam int unsigned P = data_pos(i);
      assign flip[i] = odd && (pos == PAR_W'(P));
   end

   assign data_hit = |flip;
   assign chk_hit  = odd && ((pos & (pos - 1'b1)) == '0);
   assign fatal    = (!odd && (pos != '0)) || (odd && !data_hit && !chk_hit);

   always_comb begin
      // R4: at most one data bit is ever inverted
      p_flip_onehot_r4: assert ($onehot0(flip) || $isunknown(syn));
      // R5: a check-bit location never coincides with a data-bit location
      p_hit_disjoint_r5: assert (!(data_hit && chk_hit) || $isunknown(syn));
   end

endmodule

// File: rtl/secded_outreg.sv
module secded_outreg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              async_clr,
   input  logic [DATA_W-1:0] d_in,
   input  logic              any_in,
   input  logic              fixed_in,
   input  logic              fatal_in,
   output logic [DATA_W-1:0] d_out,
   output logic              any_out,
   output logic              fixed_out,
   output logic              fatal_out
);

   always_ff @(posedge clk or posedge async_clr) begin
      if (async_clr) begin
         d_out     <= '0;
         any_out   <= 1'b0;
         fixed_out <= 1'b0;
         fatal_out <= 1'b0;
      end else begin
         d_out     <= d_in;
         any_out   <= any_in;
         fixed_out <= fixed_in;
         fatal_out <= fatal_in;
      end
   end

endmodule

// File: rtl/secded_dec13.sv
module secded_dec13
   import secded_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PAR_W  = par_bits(DATA_W),
   localparam int unsigned CODE_W = DATA_W + PAR_W + 1
) (
   input  logic              clk,
   input  logic              async_clr,
   input  logic [CODE_W-1:0] code_in,
   output logic [DATA_W-1:0] data_out,
   output logic              err_any,
   output logic              err_fixed,
   output logic              err_fatal
);

   if (DATA_W < 1 || DATA_W > 57) begin : g_bad_width
      $error("secded_dec13: DATA_W must lie in 1..57");
   end

   logic [PAR_W:0]    syn;
   logic [DATA_W-1:0] flip;
   logic              data_hit;
   logic              chk_hit;
   logic              fatal;
   logic [DATA_W-1:0] fixed_data;

   secded_syndrome #(.DATA_W(DATA_W)) u_syn (
      .code (code_in),
      .syn  (syn)
   );

   secded_locate #(.DATA_W(DATA_W)) u_loc (
      .syn      (syn),
      .flip     (flip),
      .data_hit (data_hit),
      .chk_hit  (chk_hit),
      .fatal    (fatal)
   );

   assign fixed_data = code_in[DATA_W-1:0] ^ flip;

   secded_outreg #(.DATA_W(DATA_W)) u_reg (
      .clk       (clk),
      .async_clr (async_clr),
      .d_in      (fixed_data),
      .any_in    (data_hit | fatal),
      .fixed_in  (data_hit),
      .fatal_in  (fatal),
      .d_out     (data_out),
      .any_out   (err_any),
      .fixed_out (err_fixed),
      .fatal_out (err_fatal)
   );

   // R4: a correction is never also fatal and always counts as an error
   p_fix_excl_r4: assert property (@(posedge clk) disable iff (async_clr)
      err_fixed |-> (err_any && !err_fatal));

   // R6: fatal always comes with the error flag and without correction
   p_fatal_err_r6: assert property (@(posedge clk) disable iff (async_clr)
      err_fatal |-> (err_any && !err_fixed));

   // R3: a zero syndrome passes data through with quiet flags
   p_clean_pass_r3: assert property (@(posedge clk) disable iff (async_clr)
      (syn == '0) |=> (!err_any && data_out == $past(code_in[DATA_W-1:0])));

   // R5: a check-bit error leaves data and flags alone
   p_chk_quiet_r5: assert property (@(posedge clk) disable iff (async_clr)
      chk_hit |=> (!err_any && data_out == $past(code_in[DATA_W-1:0])));

   // R8: a located data error shows up as corrected on the next edge
   p_fix_next_r8: assert property (@(posedge clk) disable iff (async_clr)
      data_hit |=> err_fixed);

   // R9: outputs are clear whenever the clear is held across an edge
   p_clr_zero_r9: assert property (@(posedge clk)
      async_clr |-> (data_out == '0 && !err_any && !err_fixed && !err_fatal));

endmodule

// File: tb/tb_secded_dec13.sv
module tb_secded_dec13;

   logic        clk;
   logic        async_clr;
   logic [12:0] code_in;
   logic [7:0]  data_out;
   logic        err_any, err_fixed, err_fatal;

   int n_checks = 0;
   int n_err    = 0;

   logic [10:0] exp_q[$];
   string       tag_q[$];

   secded_dec13 dut (
      .clk       (clk),
      .async_clr (async_clr),
      .code_in   (code_in),
      .data_out  (data_out),
      .err_any   (err_any),
      .err_fixed (err_fixed),
      .err_fatal (err_fatal)
   );

   initial clk = 1'b0;
   always #5 clk = ~clk;

   function automatic logic [10:0] outs();
      return {data_out, err_any, err_fixed, err_fatal};
   endfunction

   task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual data=%h any/fix/fatal=%b expected data=%h any/fix/fatal=%b",
                  tag, act[10:3], act[2:0], exp[10:3], exp[2:0]);
      end
   endtask

   // Behavioural encoder: positions 1..12, check bits at powers of two
   function automatic logic [12:0] encode(logic [7:0] d);
      logic [12:0] hv;
      logic [3:0]  p;
      int          k;
      hv = '0;
      k = 0;
      for (int pos = 1; pos <= 12; pos++) begin
         if (pos != 1 && pos != 2 && pos != 4 && pos != 8) begin
            hv[pos] = d[k];
            k++;
         end
      end
      for (int j = 0; j < 4; j++) begin
         p[j] = 1'b0;
         for (int pos = 1; pos <= 12; pos++)
            if (((pos >> j) & 1) != 0) p[j] = p[j] ^ hv[pos];
      end
      return {^{p, d}, p, d};
   endfunction

   task automatic apply(logic [12:0] c, logic [7:0] d, logic a, logic f, logic x, string tag);
      @(negedge clk);
      code_in = c;
      exp_q.push_back({d, a, f, x});
      tag_q.push_back(tag);
   endtask

   // Monitor: compare each result just after the edge that registers it
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            logic [10:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, outs(), e);
         end
      end
   end

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
   end

   initial begin
      async_clr = 1'b1;
      code_in   = 13'h14F3;
      #23;
      check("R9 reset", outs(), 11'h0);
      @(negedge clk);
      async_clr = 1'b0;

      apply(13'h14F0, 8'hF0, 0, 0, 0, "R1 valid 0x14F0");
      apply(13'h14F1, 8'hF0, 1, 1, 0, "R2 0x14F1");
      apply(13'h14F3, 8'hF3, 1, 0, 1, "R6 0x14F3");
      apply(13'h15F0, 8'hF0, 0, 0, 0, "R5 check bit0");
      apply(13'h04F0, 8'hF0, 0, 0, 0, "R5 overall bit");
      apply(13'h19F0, 8'hF0, 1, 0, 1, "R7 position 13");
      drain();

      // R8: output holds until the edge after a new word
      apply(13'h14F0, 8'hF0, 0, 0, 0, "R8 first word");
      @(negedge clk);
      code_in = 13'h14F3;
      #1;
      check("R8 hold before edge", outs(), {8'hF0, 3'b000});
      @(posedge clk);
      #1;
      check("R8 after edge", outs(), {8'hF3, 3'b101});

      // R9: clear between edges takes effect at once
      @(posedge clk);
      #3;
      async_clr = 1'b1;
      #1;
      check("R9 mid-cycle clear", outs(), 11'h0);
      #0.5;
      async_clr = 1'b0;
      drain();

      // Exhaustive: every data value with zero, one and two flips
      for (int dv = 0; dv < 256; dv++) begin
         logic [12:0] cw;
         cw = encode(dv[7:0]);
         apply(cw, dv[7:0], 0, 0, 0, "R3 clean");
         for (int a = 0; a < 13; a++) begin
            logic [12:0] c1;
            c1 = cw ^ (13'h1 << a);
            if (a < 8) apply(c1, dv[7:0], 1, 1, 0, "R4 data flip");
            else       apply(c1, dv[7:0], 0, 0, 0, "R5 check flip");
            for (int b = a + 1; b < 13; b++) begin
               logic [12:0] c2;
               c2 = c1 ^ (13'h1 << b);
               apply(c2, c2[7:0], 1, 0, 1, "R6 double flip");
            end
         end
      end
      drain();
      finish_run();
   end

endmodule